// File: doc/BRIEF.md
# Triggered Event Packet Serializer

This block turns accepted readout triggers into a stream of fixed-length serial packets on one bit-rate output line. Each trigger brings a 254-bit strip-hit frame, the 9-bit address of the pipeline location the frame was read from, and a latency-error flag. The block tags each accepted trigger with the value of a running trigger counter. It queues the event in a 32-entry event buffer and sends one packet per event, one bit per clock, on a clock that runs at the line bit rate (320 Mbps).

A packet occupies a slot of 304 bit periods. The first 276 bits are the active frame. The rest of the slot is filled with zeros. When another event is waiting, its slot follows the previous one with no gap. The line stays low whenever nothing is being sent. A trigger that arrives while the buffer is full is dropped, and this is reported in the next packet to be sent. An orbit-reset pulse clears the trigger counter.

Top module: `trig_pkt_ser`

## Requirements
- R1: `ser_o` is 0 after reset and in every cycle in which no packet slot is being sent.
- R2: Bits 0 and 1 of every packet (the first two on the line) are both 1.
- R3: Bit 2 of a packet equals `lat_err_i` as sampled with that packet's trigger.
- R4: Bit 3 (overflow) is 1 in the first packet that starts after a trigger was dropped, and 0 in the packets that follow, unless further drops occur.
- R5: Bits 4 to 12 carry the captured `paddr_i`, most significant bit first.
- R6: Bits 13 to 21 carry the trigger count of the event, most significant bit first. The count is 0 for the first accepted trigger after reset and goes up by one with each accepted trigger.
- R7: Bits 22 to 275 carry the strip frame in channel order: `hits_i[0]` (channel 1) at bit 22, up to `hits_i[253]` at bit 275.
- R8: Bits 276 to 303 of the slot are 0. When an event is pending at the end of a slot, the next packet's bit 0 follows bit 303 on the very next clock.
- R9: An orbit-reset pulse sets the count so that the next accepted trigger reports 0. A trigger in the same cycle as the orbit reset reports 0, and the trigger after it reports 1.
- R10: Up to 32 events wait in the buffer while one more is being sent. A trigger arriving with the buffer full is dropped: it produces no packet and does not advance the count.
- R11: With the block idle and the buffer empty, a trigger sampled on clock edge k puts bit 0 of its packet on `ser_o` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one output bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Readout trigger, one cycle per event |
| hits_i | input | 254 | Strip-hit frame; bit 0 is channel 1 |
| paddr_i | input | 9 | Pipeline address of the frame |
| lat_err_i | input | 1 | Latency-error flag for the frame |
| orbit_rst_i | input | 1 | Orbit-reset pulse, clears the trigger count |
| ser_o | output | 1 | Serial packet output |

## Verification
The hardest situation to reach is a full buffer. Overflow needs 33 events in flight at once, and the drop must land while a slot is being sent. Only then is it reported in the second packet and not in the first. The bench issues 34 triggers on consecutive cycles from idle. It then reads the 33 resulting packets back to back. This checks the overflow flag, the uninterrupted slot spacing and the count that skips the dropped trigger. A final trigger shows that the flag has cleared and the count has resumed. Orbit reset alone and orbit reset together with a trigger are driven as separate directed cases.

// File: rtl/trig_pkt_ser_pkg.sv
package trig_pkt_ser_pkg;
   localparam int unsigned STRIP_W_DEF = 254;
   localparam int unsigned ADDR_W_DEF  = 9;
   localparam int unsigned CNT_W_DEF   = 9;
   localparam int unsigned DEPTH_DEF   = 32;
   localparam int unsigned SLOT_DEF    = 304;
   localparam int unsigned START_W     = 2;
   localparam int unsigned ERR_W       = 2;

   typedef enum logic [0:0] {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_e;
endpackage

// File: rtl/trig_pkt_ser_l1cnt.sv
module trig_pkt_ser_l1cnt #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             orbit_rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] evt_count
);
   // an event accepted in the orbit-reset cycle is the first of the new orbit
   assign evt_count = orbit_rst ? '0 : count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (inc) begin
         count_q <= evt_count + CNT_W'(1);
      end else if (orbit_rst) begin
         count_q <= '0;
      end
   end
endmodule

// File: rtl/trig_pkt_ser_evbuf.sv
module trig_pkt_ser_evbuf #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("event buffer needs at least two entries");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [OCC_W-1:0] occ_q;
   logic             do_push, do_pop;

   assign empty   = (occ_q == '0);
   assign full    = (occ_q == OCC_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_q];

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_q] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         occ_q <= '0;
      end else begin
         if (do_push) begin
            wr_q <= (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
         end
         if (do_pop) begin
            rd_q <= (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
         end
         case ({do_push, do_pop})
            2'b10:   occ_q <= occ_q + OCC_W'(1);
            2'b01:   occ_q <= occ_q - OCC_W'(1);
            default: occ_q <= occ_q;
         endcase
      end
   end
endmodule

// File: rtl/trig_pkt_ser_shift.sv
module trig_pkt_ser_shift
   import trig_pkt_ser_pkg::*;
#(
   parameter int unsigned PKT_W    = 276,
   parameter int unsigned SLOT_LEN = 304
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PKT_W-1:0] pkt,
   output logic             ready,
   output logic             busy,
   output logic             ser
);
   localparam int unsigned CW = $clog2(SLOT_LEN);
   localparam logic [CW-1:0] SLOT_END = CW'(SLOT_LEN - 1);

   if (SLOT_LEN < PKT_W) begin : g_bad_slot
      $error("slot shorter than active packet");
   end

   ser_state_e       state_q;
   logic [PKT_W-1:0] shreg_q;
   logic [CW-1:0]    pos_q;
   logic             at_end;

   assign at_end = (pos_q == SLOT_END);
   assign busy   = (state_q == SER_SEND);
   assign ready  = !busy || at_end;
   // zeros shift in behind the frame, which gives the slot padding
   assign ser    = shreg_q[PKT_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         shreg_q <= '0;
         pos_q   <= '0;
      end else if (ready && start) begin
         state_q <= SER_SEND;
         shreg_q <= pkt;
         pos_q   <= '0;
      end else if (busy && at_end) begin
         state_q <= SER_IDLE;
         shreg_q <= '0;
         pos_q   <= '0;
      end else if (busy) begin
         shreg_q <= {shreg_q[PKT_W-2:0], 1'b0};
         pos_q   <= pos_q + CW'(1);
      end
   end
endmodule

// File: rtl/trig_pkt_ser.sv
module trig_pkt_ser
   import trig_pkt_ser_pkg::*;
#(
   parameter int unsigned STRIP_W  = STRIP_W_DEF,
   parameter int unsigned ADDR_W   = ADDR_W_DEF,
   parameter int unsigned CNT_W    = CNT_W_DEF,
   parameter int unsigned DEPTH    = DEPTH_DEF,
   parameter int unsigned SLOT_LEN = SLOT_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_i,
   input  logic [STRIP_W-1:0] hits_i,
   input  logic [ADDR_W-1:0]  paddr_i,
   input  logic               lat_err_i,
   input  logic               orbit_rst_i,
   output logic               ser_o
);
   localparam int unsigned EVT_W = 1 + ADDR_W + CNT_W + STRIP_W;
   localparam int unsigned PKT_W = START_W + ERR_W + ADDR_W + CNT_W + STRIP_W;

   if (STRIP_W < 2 || ADDR_W < 1 || CNT_W < 1) begin : g_bad_fields
      $error("field widths out of range");
   end

   logic               accept, drop, buf_full, buf_empty;
   logic               ser_start, ser_ready, ser_busy;
   logic               ovf_q;
   logic [CNT_W-1:0]   l1_count_q, l1_evt;
   logic [EVT_W-1:0]   evt_in, evt_out;
   logic               ev_lat;
   logic [ADDR_W-1:0]  ev_paddr;
   logic [CNT_W-1:0]   ev_l1;
   logic [STRIP_W-1:0] ev_hits, strip_tx;
   logic [PKT_W-1:0]   pkt;

   assign accept = trig_i && !buf_full;
   assign drop   = trig_i && buf_full;

   trig_pkt_ser_l1cnt #(.CNT_W(CNT_W)) u_l1cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .orbit_rst (orbit_rst_i),
      .inc       (accept),
      .count_q   (l1_count_q),
      .evt_count (l1_evt)
   );

   assign evt_in = {lat_err_i, paddr_i, l1_evt, hits_i};

   trig_pkt_ser_evbuf #(.W(EVT_W), .DEPTH(DEPTH)) u_evbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .wdata (evt_in),
      .pop   (ser_start),
      .rdata (evt_out),
      .empty (buf_empty),
      .full  (buf_full)
   );

   assign {ev_lat, ev_paddr, ev_l1, ev_hits} = evt_out;

   // channel 1 leaves first, so it takes the top of the strip field
   for (genvar i = 0; i < STRIP_W; i++) begin : g_chan
      assign strip_tx[STRIP_W-1-i] = ev_hits[i];
   end

   assign pkt       = {{START_W{1'b1}}, ev_lat, ovf_q, ev_paddr, ev_l1, strip_tx};
   assign ser_start = ser_ready && !buf_empty;

   // sticky drop flag, consumed by the packet that starts next
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= drop || (ovf_q && !ser_start);
      end
   end

   trig_pkt_ser_shift #(.PKT_W(PKT_W), .SLOT_LEN(SLOT_LEN)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ser_start),
      .pkt   (pkt),
      .ready (ser_ready),
      .busy  (ser_busy),
      .ser   (ser_o)
   );
endmodule

// File: rtl/trig_pkt_ser_chk.sv
module trig_pkt_ser_chk #(
   parameter int unsigned SLOT_LEN = 304,
   parameter int unsigned PKT_W    = 276,
   parameter int unsigned CNT_W    = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_o,
   input logic             busy,
   input logic             start,
   input logic             full,
   input logic             trig_i,
   input logic             orbit_rst_i,
   input logic [CNT_W-1:0] l1_q,
   input logic             ovf_q
);
   localparam int unsigned CW = $clog2(SLOT_LEN + 1);
   logic [CW-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (start) begin
         pos_q <= '0;
      end else if (busy && pos_q != CW'(SLOT_LEN)) begin
         pos_q <= pos_q + CW'(1);
      end
   end

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_o);
   // R2
   start_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ser_o ##1 ser_o);
   // R8
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pos_q >= CW'(PKT_W)) |-> !ser_o);
   // R8
   slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |-> (pos_q == CW'(SLOT_LEN - 1)));
   // R4
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && full) |=> ovf_q);
   // R10
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && full && !orbit_rst_i) |=> $stable(l1_q));
   // R9
   orbit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (orbit_rst_i && !(trig_i && !full)) |=> (l1_q == '0));
   // R9
   orbit_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (orbit_rst_i && trig_i && !full) |=> (l1_q == CNT_W'(1)));
endmodule

bind trig_pkt_ser trig_pkt_ser_chk #(
   .SLOT_LEN (SLOT_LEN),
   .PKT_W    (PKT_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ser_o       (ser_o),
   .busy        (ser_busy),
   .start       (ser_start),
   .full        (buf_full),
   .trig_i      (trig_i),
   .orbit_rst_i (orbit_rst_i),
   .l1_q        (l1_count_q),
   .ovf_q       (ovf_q)
);

// File: tb/trig_pkt_ser_tb.sv
`timescale 1ns/1ps
module trig_pkt_ser_tb;
   localparam int CLK_PERIOD = 4;
   localparam int SW   = 254;
   localparam int AW   = 9;
   localparam int CW   = 9;
   localparam int SLOT = 304;
   localparam int PAD  = SLOT - (4 + AW + CW + SW);
   localparam int NVEC = 6;
   // {paddr, latency error, hit pattern}
   localparam logic [13:0] VEC [NVEC] = '{
      {9'h1A5, 1'b1, 4'd2}, {9'h000, 1'b0, 4'd0}, {9'h1FF, 1'b0, 4'd1},
      {9'h0F0, 1'b1, 4'd3}, {9'h100, 1'b0, 4'd4}, {9'h055, 1'b1, 4'd5}};

   logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, lat = 1'b0, orbit = 1'b0;
   logic [SW-1:0] hits = '0;
   logic [AW-1:0] paddr = '0;
   logic ser;
   int checks = 0, errors = 0, cycles = 0;
   int l1_model = 0;

   trig_pkt_ser u_dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .hits_i(hits), .paddr_i(paddr),
      .lat_err_i(lat), .orbit_rst_i(orbit), .ser_o(ser));

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [SW-1:0] make_hits(input int sel);
      logic [SW-1:0] h;
      for (int i = 0; i < SW; i++) begin
         if (sel == 0)      h[i] = 1'b0;
         else if (sel == 1) h[i] = 1'b1;
         else               h[i] = (((i * (sel + 3) + sel) % 5) == 0) ^ (i == 0);
      end
      return h;
   endfunction

   task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reads one slot; bit 0 of the slot lands in s[SLOT-1]
   task automatic get_slot(output logic [SLOT-1:0] s, input bit wait_start);
      int t = 0;
      if (wait_start) begin
         while (ser !== 1'b1 && t < 2000) begin
            @(negedge clk);
            t++;
         end
         if (t >= 2000) chk("R2 packet start timeout", 0, 1);
      end
      for (int j = 0; j < SLOT; j++) begin
         s[SLOT-1-j] = ser;
         if (j < SLOT - 1) @(negedge clk);
      end
   endtask

   task automatic check_slot(input logic [SLOT-1:0] s, input logic el, input logic eo,
                             input logic [AW-1:0] ea, input int el1, input logic [SW-1:0] eh);
      logic [SW-1:0] strip;
      for (int i = 0; i < SW; i++) strip[SW-1-i] = eh[i];
      chk("R2 start bits", SW'(s[SLOT-1 -: 2]), SW'(2'b11));
      chk("R3 latency bit", SW'(s[SLOT-3]), SW'(el));
      chk("R4 overflow bit", SW'(s[SLOT-4]), SW'(eo));
      chk("R5 pipeline address", SW'(s[SLOT-5 -: AW]), SW'(ea));
      chk("R6 trigger count", SW'(s[SLOT-5-AW -: CW]), SW'(CW'(el1)));
      chk("R7 strip data", s[SLOT-5-AW-CW -: SW], strip);
      chk("R8 slot padding", SW'(s[PAD-1:0]), '0);
   endtask

   // one trigger from idle, with latency and idle-after checks
   task automatic send_one(input logic [AW-1:0] a, input logic e, input int sel,
                           input logic orb, input int el1, input logic eo);
      logic [SLOT-1:0] s;
      paddr = a; lat = e; hits = make_hits(sel); trig = 1'b1; orbit = orb;
      @(negedge clk);
      trig = 1'b0; orbit = 1'b0;
      chk("R11 no output one edge after trigger", SW'(ser), '0);
      @(negedge clk);
      chk("R11 bit 0 two edges after trigger", SW'(ser), SW'(1));
      get_slot(s, 1'b0);
      check_slot(s, e, eo, a, el1, make_hits(sel));
      @(negedge clk);
      chk("R1 idle after slot", SW'(ser), '0);
   endtask

   initial begin
      logic [SLOT-1:0] s;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ser !== 1'b0) seen = 1'b1;
         end
         chk("R1 reset state", SW'(seen), '0);
      end

      // table walk: count starts at 0 and steps per trigger (R6)
      for (int v = 0; v < NVEC; v++) begin
         send_one(VEC[v][13:5], VEC[v][4], int'(VEC[v][3:0]), 1'b0, l1_model, 1'b0);
         l1_model++;
         repeat (5) @(negedge clk);
      end

      // R10 / R4: 34 triggers back to back, the last one is dropped
      base = l1_model;
      fork
         begin
            for (int j = 0; j < 34; j++) begin
               paddr = AW'(j); lat = (j % 3 == 0); hits = make_hits(j + 10); trig = 1'b1;
               @(negedge clk);
            end
            trig = 1'b0;
         end
         begin
            for (int k = 0; k < 33; k++) begin
               get_slot(s, k == 0);
               check_slot(s, (k % 3 == 0), (k == 1), AW'(k), base + k, make_hits(k + 10));
               if (k < 32) @(negedge clk);
            end
         end
      join
      @(negedge clk);
      chk("R10 no packet for dropped trigger", SW'(ser), '0);
      l1_model = base + 33;
      repeat (4) @(negedge clk);
      send_one(9'h0AA, 1'b0, 7, 1'b0, l1_model, 1'b0);

      // R9: orbit reset alone, then together with a trigger
      orbit = 1'b1;
      @(negedge clk);
      orbit = 1'b0;
      repeat (2) @(negedge clk);
      send_one(9'h123, 1'b1, 8, 1'b0, 0, 1'b0);
      send_one(9'h0C3, 1'b0, 9, 1'b1, 0, 1'b0);
      send_one(9'h03C, 1'b1, 1, 1'b0, 1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule